// File: doc/BRIEF.md
# Outer-Bank PRG Address Mapper

This block forms the program ROM address for a cartridge mapper with 512 KiB of program storage. The CPU writes bank registers anywhere in the $8000-$FFFF range. Four one-bit outer registers each name a 256 KiB half of the ROM. A four-bit inner register names a 16 KiB window in the lower CPU window. The upper CPU window always shows the top 16 KiB slot of the active half.

The live picture-bus address bits 11 and 10 choose which outer register is active. Software normally loads all four with the same value. If they differ, the half shown to the CPU changes with the picture-bus address as it moves. The address output has no register in its path, so it follows that selection and every register change in the same cycle.

Top module: `prg_outer_map`

## Requirements
- R1: A write with CPU address bit 15 set and CPU address bits [3:0] equal to 0, 1, 2 or 3 stores data bit 0 into the outer register with that index. The register is captured at the clock edge where the write strobe is high. All other data bits are ignored.
- R2: A write with CPU address bit 15 set and address bits [3:0] equal to 8 stores data bits [3:0] into the inner register. A write to any other index changes no register.
- R3: A write strobe with CPU address bit 15 clear changes no register.
- R4: The outer register whose index equals {ppu A11, ppu A10} drives output bit 18. This selection is combinational.
- R5: When CPU A14 is 0, output bits [17:14] equal the inner register.
- R6: When CPU A14 is 1, output bits [17:14] equal 4'hF, and output bit 18 still follows the active outer register.
- R7: Output bits [13:0] equal CPU address bits [13:0].
- R8: An active-low asynchronous reset clears all four outer registers and the inner register.
- R9: A change to the outer registers shows in both windows right after the write edge, with no write to the inner register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | Write strobe |
| ppu_a11_i | input | 1 | Picture-bus address bit 11 |
| ppu_a10_i | input | 1 | Picture-bus address bit 10 |
| prg_addr_o | output | 19 | Program ROM address |

## Verification
On every cycle, assertions check the following:
- the upper window reads inner slot 15;
- the low address bits pass through unchanged;
- a write outside $8000-$FFFF or to an unused index leaves the registers as they were;
- a write to an outer register takes effect.

Only the bench scenarios show the combinational sweep of the picture-bus bits with unequal outer values. They also show that both windows switch halves at once after an outer write, and that the reset values hold.

// File: rtl/prg_outer_pkg.sv
package prg_outer_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned INNER_W = 4;
  localparam int unsigned N_OUTER = 4;
  localparam int unsigned WIN_W   = 14;
  localparam int unsigned PRG_AW  = 1 + INNER_W + WIN_W;
  localparam logic [3:0]  IDX_INNER = 4'h8;
endpackage

// File: rtl/prg_reg_file.sv
module prg_reg_file
  import prg_outer_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CPU_AW-1:0]   cpu_addr_i,
  input  logic [7:0]          cpu_data_i,
  input  logic                cpu_we_i,
  output logic [N_OUTER-1:0]  outer_q_o,
  output logic [INNER_W-1:0]  inner_q_o
);
  logic hit;
  assign hit = cpu_we_i & cpu_addr_i[CPU_AW-1];

  for (genvar g = 0; g < N_OUTER; g++) begin : g_outer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) outer_q_o[g] <= 1'b0;
      else if (hit && cpu_addr_i[3:0] == 4'(g)) outer_q_o[g] <= cpu_data_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inner_q_o <= '0;
    else if (hit && cpu_addr_i[3:0] == IDX_INNER) inner_q_o <= cpu_data_i[INNER_W-1:0];
  end

  p_no_write_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && !cpu_addr_i[CPU_AW-1]) |=> $stable(outer_q_o) && $stable(inner_q_o));
  p_unused_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i[3:0] > 4'd3 && cpu_addr_i[3:0] != IDX_INNER) |=> $stable(outer_q_o) && $stable(inner_q_o));
  p_outer_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i[CPU_AW-1] && cpu_addr_i[3:0] == 4'd0) |=> outer_q_o[0] == $past(cpu_data_i[0]));
endmodule

// File: rtl/prg_addr_gen.sv
module prg_addr_gen
  import prg_outer_pkg::*;
(
  input  logic [N_OUTER-1:0]  outer_q_i,
  input  logic [INNER_W-1:0]  inner_q_i,
  input  logic [1:0]          ppu_sel_i,
  input  logic [WIN_W:0]      cpu_win_i,
  output logic [PRG_AW-1:0]   prg_addr_o
);
  logic               outer_bit;
  logic [INNER_W-1:0] slot;
  always_comb begin
    outer_bit = outer_q_i[ppu_sel_i];
    slot      = cpu_win_i[WIN_W] ? {INNER_W{1'b1}} : inner_q_i;
    prg_addr_o = {outer_bit, slot, cpu_win_i[WIN_W-1:0]};
  end

  always_comb begin
    if (cpu_win_i[WIN_W]) a_fixed_r6: assert (prg_addr_o[PRG_AW-2 -: INNER_W] == {INNER_W{1'b1}});
    a_pass_r7: assert (prg_addr_o[WIN_W-1:0] == cpu_win_i[WIN_W-1:0]);
  end
endmodule

// File: rtl/prg_outer_map.sv
module prg_outer_map
  import prg_outer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_we_i,
  input  logic              ppu_a11_i,
  input  logic              ppu_a10_i,
  output logic [18:0]       prg_addr_o
);
  logic [N_OUTER-1:0] outer_q;
  logic [INNER_W-1:0] inner_q;

  prg_reg_file u_regs (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i,
    .outer_q_o(outer_q), .inner_q_o(inner_q)
  );

  prg_addr_gen u_gen (
    .outer_q_i(outer_q), .inner_q_i(inner_q),
    .ppu_sel_i({ppu_a11_i, ppu_a10_i}),
    .cpu_win_i(cpu_addr_i[WIN_W:0]),
    .prg_addr_o(prg_addr_o)
  );
endmodule

// File: tb/prg_outer_map_tb.sv
module prg_outer_map_tb;
  logic clk = 0, rst_ni = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_data = 0;
  logic cpu_we = 0, a11 = 0, a10 = 0;
  logic [18:0] prg_addr;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  prg_outer_map u_dut (.clk_i(clk), .rst_ni, .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_we_i(cpu_we), .ppu_a11_i(a11), .ppu_a10_i(a10), .prg_addr_o(prg_addr));

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_data = d; cpu_we = 1;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] a, input logic [1:0] sel, input logic [18:0] exp);
    cpu_addr = a; {a11, a10} = sel; #1;
    checks++;
    if (prg_addr !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, prg_addr, exp);
    end
  endtask

  // outer regs after setup: 1,0,0,1 ; inner = 5
  typedef struct packed { logic [15:0] a; logic [1:0] sel; logic [18:0] exp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{16'h8123, 2'd0, {1'b1, 4'h5, 14'h0123}},
    '{16'h8123, 2'd1, {1'b0, 4'h5, 14'h0123}},
    '{16'h8123, 2'd2, {1'b0, 4'h5, 14'h0123}},
    '{16'h8123, 2'd3, {1'b1, 4'h5, 14'h0123}},
    '{16'hFFFC, 2'd0, {1'b1, 4'hF, 14'h3FFC}},
    '{16'hC000, 2'd1, {1'b0, 4'hF, 14'h0000}},
    '{16'hE5A5, 2'd2, {1'b0, 4'hF, 14'h25A5}},
    '{16'hBFFF, 2'd3, {1'b1, 4'h5, 14'h3FFF}}
  };

  initial begin
    #1;
    chk("R8 reset", 16'hA000, 2'd3, {1'b0, 4'h0, 14'h2000});
    #50 rst_ni = 1;
    chk("R8 after release", 16'hC001, 2'd0, {1'b0, 4'hF, 14'h0001});
    wr(16'h8000, 8'hFF); wr(16'h8001, 8'hFE); wr(16'h8002, 8'h02); wr(16'h8003, 8'h81);
    wr(16'h8008, 8'hF5);
    for (int i = 0; i < 8; i++)
      chk("R1/R4/R5/R6/R7 vec", VECS[i].a, VECS[i].sel, VECS[i].exp);
    // R3: low-range write ignored
    wr(16'h0001, 8'h01); wr(16'h7FF8, 8'h0A);
    chk("R3 outer1 unchanged", 16'h8000, 2'd1, {1'b0, 4'h5, 14'h0});
    chk("R3 inner unchanged", 16'h8000, 2'd0, {1'b1, 4'h5, 14'h0});
    // R2: unused index ignored; mirror at $F008 writes inner
    wr(16'h8004, 8'h01); wr(16'h8009, 8'h0C);
    chk("R2 unused index", 16'h8000, 2'd0, {1'b1, 4'h5, 14'h0});
    wr(16'hF008, 8'h0A);
    chk("R2 inner at F008", 16'h9000, 2'd1, {1'b0, 4'hA, 14'h1000});
    // R9: outer change applies to both windows at once
    @(negedge clk); cpu_addr = 16'h8002; cpu_data = 8'h01; cpu_we = 1;
    @(posedge clk); #1 cpu_we = 0;
    chk("R9 lower window", 16'h8010, 2'd2, {1'b1, 4'hA, 14'h0010});
    chk("R9 upper window", 16'hC010, 2'd2, {1'b1, 4'hF, 14'h0010});
    // R8: asynchronous reset mid-run
    rst_ni = 0; #1;
    chk("R8 async clear", 16'h8000, 2'd0, {1'b0, 4'h0, 14'h0});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule